// File: doc/BRIEF.md
# Chip-Select Bounds Address Decoder

This block takes a physical address and decides which of four memory chip-select rows owns it. Each row carries one programmable 32-bit bounds word that names an inclusive range of 16 MiB granules. The address is reduced to its granule number (bits 35:24). Every populated row is compared against that number at the same time, and the lowest-numbered row that matches wins.

A lookup is started by pulsing `addr_valid_i`. On the next cycle the registered result appears with a one-cycle `res_valid_o` strobe: the selected row index, a hit flag and an out-of-range flag. The result is held until the next lookup. Bounds words are loaded through a simple write port, one row per cycle.

Top module: `cs_bounds_decoder`

## Requirements
- R1: After reset `res_valid_o`, `hit_o`, `oor_o` and `row_o` are all 0. All bounds words are zero, so every row is unpopulated and any lookup made before programming reports out of range.
- R2: When `wr_en_i` is high at a clock edge, the bounds word of row `wr_row_i` is loaded from `wr_data_i`. Bits 31:16 hold the first granule and bits 15:0 hold the last granule.
- R3: A row matches when its first granule <= addr_i[35:24] <= its last granule. The last granule is inclusive: an address at the top byte of the last granule matches.
- R4: A row whose first and last granule fields are equal is unpopulated and never matches.
- R5: When several rows match, the row with the lowest index is reported.
- R6: When no row matches, `oor_o` is 1, `hit_o` is 0 and `row_o` equals 4 (the row count). When a row matches, `hit_o` is 1, `oor_o` is 0 and `row_o` is that row's index.
- R7: A lookup sampled with `addr_valid_i` high at one edge shows its result after that edge. `res_valid_o` is high for exactly that cycle. While no lookup is made, `row_o`, `hit_o` and `oor_o` keep their last values.
- R8: A lookup and a write made at the same edge: the lookup uses the bounds as they stood before the write.
- R9: A row whose first granule is above its last granule never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bounds write strobe |
| wr_row_i | input | 2 | Row index for the write |
| wr_data_i | input | 32 | Bounds word: first granule [31:16], last granule [15:0] |
| addr_valid_i | input | 1 | Lookup strobe |
| addr_i | input | 36 | Physical address to decode |
| res_valid_o | output | 1 | Result strobe, one cycle after the lookup |
| row_o | output | 3 | Selected row, or 4 when out of range |
| hit_o | output | 1 | A populated row matched |
| oor_o | output | 1 | No row matched |

## Verification
The bench uses the default parameters: four rows, a 36-bit address and 16 MiB granules. With only 12 granule bits, the lowest granule (0) and the highest granule (0xFFF) are both easy to reach, and so is the top byte of an end granule. The row layout makes two rows overlap, so priority is tested. It also includes one unpopulated row and one reversed range. A write to a row is placed in the same cycle as a lookup of that row, which exposes the old-versus-new bounds ordering.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int unsigned CS_FIELD_W = 16;
  localparam int unsigned CS_WORD_W  = 2 * CS_FIELD_W;

  typedef struct packed {
    logic [CS_FIELD_W-1:0] first_g;
    logic [CS_FIELD_W-1:0] last_g;
  } bounds_t;
endpackage

// File: rtl/cs_bounds_regs.sv
module cs_bounds_regs
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_ROWS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [SEL_W-1:0]              wr_row_i,
  input  logic [CS_WORD_W-1:0]          wr_data_i,
  output bounds_t [NUM_ROWS-1:0]        bounds_o
);
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bounds_o[g] <= '0;
      else if (wr_en_i && (wr_row_i == SEL_W'(g))) bounds_o[g] <= bounds_t'(wr_data_i);
    end
  end
endmodule

// File: rtl/cs_row_match.sv
module cs_row_match
  import cs_dec_pkg::*;
(
  input  bounds_t                 bounds_i,
  input  logic [CS_FIELD_W-1:0]   gran_i,
  output logic                    match_o
);
  logic populated;
  assign populated = (bounds_i.first_g != bounds_i.last_g);
  // inclusive on both ends; reversed ranges fall out of the compare
  assign match_o = populated && (gran_i >= bounds_i.first_g) && (gran_i <= bounds_i.last_g);
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int unsigned NUM_ROWS = 4,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS + 1)
) (
  input  logic [NUM_ROWS-1:0] match_i,
  output logic [ROW_W-1:0]    row_o,
  output logic                hit_o
);
  always_comb begin
    row_o = ROW_W'(NUM_ROWS);
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (match_i[i]) row_o = ROW_W'(i);
    end
    hit_o = |match_i;
  end
endmodule

// File: rtl/cs_bounds_decoder.sv
module cs_bounds_decoder
  import cs_dec_pkg::*;
#(
  parameter int unsigned NUM_ROWS   = 4,
  parameter int unsigned ADDR_W     = 36,
  parameter int unsigned GRAN_SHIFT = 24,
  localparam int unsigned SEL_W     = $clog2(NUM_ROWS),
  localparam int unsigned ROW_W     = $clog2(NUM_ROWS + 1),
  localparam int unsigned GRAN_W    = ADDR_W - GRAN_SHIFT
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SEL_W-1:0]      wr_row_i,
  input  logic [CS_WORD_W-1:0]  wr_data_i,
  input  logic                  addr_valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic                  res_valid_o,
  output logic [ROW_W-1:0]      row_o,
  output logic                  hit_o,
  output logic                  oor_o
);
  bounds_t [NUM_ROWS-1:0] bounds;
  logic [NUM_ROWS-1:0]    match;
  logic [CS_FIELD_W-1:0]  gran;
  logic [GRAN_W-1:0]      gran_raw;
  logic [ROW_W-1:0]       sel_row;
  logic                   sel_hit;

  assign gran_raw = addr_i[ADDR_W-1:GRAN_SHIFT];
  assign gran     = CS_FIELD_W'(gran_raw);

  cs_bounds_regs #(.NUM_ROWS(NUM_ROWS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_row_i  (wr_row_i),
    .wr_data_i (wr_data_i),
    .bounds_o  (bounds)
  );

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_match
    cs_row_match u_match (
      .bounds_i (bounds[g]),
      .gran_i   (gran),
      .match_o  (match[g])
    );
  end

  cs_prio_sel #(.NUM_ROWS(NUM_ROWS)) u_sel (
    .match_i (match),
    .row_o   (sel_row),
    .hit_o   (sel_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      row_o       <= '0;
      hit_o       <= 1'b0;
      oor_o       <= 1'b0;
    end else begin
      res_valid_o <= addr_valid_i;
      if (addr_valid_i) begin
        row_o <= sel_row;
        hit_o <= sel_hit;
        oor_o <= !sel_hit;
      end
    end
  end
endmodule

// File: rtl/cs_bounds_decoder_chk.sv
module cs_bounds_decoder_chk #(
  parameter int unsigned NUM_ROWS = 4,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             addr_valid_i,
  input logic             res_valid_o,
  input logic [ROW_W-1:0] row_o,
  input logic             hit_o,
  input logic             oor_o
);
  AST_RESULT_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i |=> res_valid_o); // R7
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> !res_valid_o); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> ($stable(row_o) && $stable(hit_o) && $stable(oor_o))); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (hit_o != oor_o)); // R6
  AST_OOR_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && oor_o) |-> (row_o == ROW_W'(NUM_ROWS))); // R6
  AST_HIT_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && hit_o) |-> (row_o < ROW_W'(NUM_ROWS))); // R6
endmodule

bind cs_bounds_decoder cs_bounds_decoder_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_valid_i (addr_valid_i),
  .res_valid_o  (res_valid_o),
  .row_o        (row_o),
  .hit_o        (hit_o),
  .oor_o        (oor_o)
);

// File: tb/cs_bounds_decoder_bench.sv
module cs_bounds_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_row_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        addr_valid_i = 1'b0;
  logic [35:0] addr_i = '0;
  logic        res_valid_o;
  logic [2:0]  row_o;
  logic        hit_o;
  logic        oor_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string req = "R1";

  int unsigned mdl_b [4];
  bit exp_valid = 0;
  int exp_row = 0;
  bit exp_hit = 0;
  bit exp_oor = 0;

  always #4 clk_i = ~clk_i;

  cs_bounds_decoder u_cs_bounds_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_row_i(wr_row_i),
    .wr_data_i(wr_data_i), .addr_valid_i(addr_valid_i), .addr_i(addr_i),
    .res_valid_o(res_valid_o), .row_o(row_o), .hit_o(hit_o), .oor_o(oor_o)
  );

  function automatic logic [35:0] mk(input int g, input logic [23:0] low);
    return {g[11:0], low};
  endfunction

  task automatic ref_lookup(input logic [35:0] a);
    int g = int'(a[35:24]);
    exp_row = 4;
    exp_hit = 0;
    for (int i = 3; i >= 0; i--) begin
      int s = int'(mdl_b[i] >> 16);
      int e = int'(mdl_b[i] & 32'hffff);
      if (s != e && g >= s && g <= e) begin
        exp_row = i;
        exp_hit = 1;
      end
    end
    exp_oor = !exp_hit;
  endtask

  // one cycle: inputs set after a falling edge, model advanced at the rising edge
  task automatic step(input bit v, input logic [35:0] a, input bit w,
                      input logic [1:0] r, input logic [31:0] d);
    addr_valid_i = v; addr_i = a; wr_en_i = w; wr_row_i = r; wr_data_i = d;
    @(posedge clk_i);
    exp_valid = v;
    if (v) ref_lookup(a);
    if (w) mdl_b[r] = d;
    @(negedge clk_i);
    addr_valid_i = 0; wr_en_i = 0;
  endtask

  task automatic look(input string tag, input logic [35:0] a);
    req = tag;
    step(1, a, 0, 0, 0);
  endtask

  task automatic wr(input logic [1:0] r, input logic [31:0] d);
    req = "R2";
    step(0, '0, 1, r, d);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      checks++;
      if (res_valid_o !== exp_valid || row_o !== 3'(exp_row) ||
          hit_o !== exp_hit || oor_o !== exp_oor) begin
        errors++;
        $display("FAIL %s: got v=%0b row=%0d hit=%0b oor=%0b exp v=%0b row=%0d hit=%0b oor=%0b",
                 req, res_valid_o, row_o, hit_o, oor_o, exp_valid, exp_row, exp_hit, exp_oor);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl_b[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset outputs, then unprogrammed lookups are out of range
    step(0, '0, 0, 0, 0);
    look("R1", mk(0, 24'h0));
    look("R1", mk(12'h7ff, 24'h123456));
    // R2: program rows
    wr(0, 32'h0001_0002);
    wr(1, 32'h0003_0003);
    wr(2, 32'h0002_0005);
    wr(3, 32'h0010_000f);
    look("R6", mk(0, 24'hffffff));
    look("R3", mk(1, 24'h0));
    look("R5", mk(2, 24'hffffff));
    look("R4", mk(3, 24'h000000));
    look("R3", mk(5, 24'hffffff));
    look("R6", mk(6, 24'h0));
    look("R9", mk(16, 24'h0));
    look("R9", mk(15, 24'h800000));
    // R7: idle cycles hold the result
    req = "R7";
    step(0, '0, 0, 0, 0);
    step(0, '0, 0, 0, 0);
    look("R7", mk(1, 24'h5));
    look("R7", mk(4, 24'h5));
    // full-range row 3 reaches top granule
    wr(3, 32'h0000_0fff);
    look("R3", mk(12'hfff, 24'hffffff));
    look("R3", mk(0, 24'h0));
    // R8: write row 0 unpopulated while looking up its granule
    req = "R8";
    step(1, mk(1, 24'h10), 1, 0, 32'h0000_0000);
    look("R8", mk(1, 24'h10));
    look("R4", mk(2, 24'h0));
    step(0, '0, 0, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule